// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block recovers asynchronous serial characters from a single receive line. The line is sampled only on clock cycles where an external oversampling enable (`tick`) is high. Each bit period spans either sixteen or eight such ticks, and the choice is made by a speed-select input. The value of every bit is decided by a majority of three consecutive samples taken near the middle of the bit, which rejects short noise spikes.

A character consists of one low start bit, five to nine data bits sent least significant first, an optional parity bit (even or odd), and one stop bit. When the stop bit has been voted, the receiver presents the data word together with a framing flag and a parity flag, and pulses a valid strobe. It returns to idle at once, without waiting for the rest of the stop bit, so a following start edge can be caught on the very next tick. The block does not generate the tick and has no buffering. The surrounding logic supplies the tick and consumes each word on its strobe.

Top module: `uart_mv_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `rx_valid`, `frame_err` and `parity_err` are 0 and `rx_data` is all zeros.
- R2: With `dbl_speed`=0 a bit lasts 16 ticks. Sample 1 is the tick on which the synchronised line is first seen low after a high sample in idle, and each bit is the majority of its samples 8, 9 and 10.
- R3: With `dbl_speed`=1 a bit lasts 8 ticks and is the majority of its samples 4, 5 and 6, numbered the same way.
- R4: `cfg_bits` selects the data bit count. Values below 5 act as 5 and values above 9 act as 9. Bits arrive least significant first and are placed in `rx_data` from bit 0 upward, with unused upper bits 0.
- R5: `cfg_parity` selects the parity mode: 0 and 3 mean no parity bit, 1 means even and 2 means odd. A mismatch sets `parity_err` for that word. With no parity bit, `parity_err` is 0.
- R6: The stop bit uses the same vote. If it resolves to 0, `frame_err` is 1 for that word.
- R7: `rx_valid` is high for exactly one clock, the clock after the tick that votes the stop bit, whatever the error flags. `rx_data` and both flags change only together with that pulse and hold their values otherwise.
- R8: If the start bit's vote resolves to 1, no word is produced and the receiver goes back to waiting for a falling edge.
- R9: After the stop vote the receiver is idle. A low sample on the next tick, following the high voting sample, starts a new character.
- R10: Speed, data bit count and parity mode are captured on the tick that detects the start edge. Changes to them during a character have no effect on that character.
- R11: `rxd` passes through a two-flop synchroniser clocked by `clk`. Cycles with `tick` low leave the receiver's sampling state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling enable, one clock wide |
| rxd | input | 1 | Asynchronous serial line, idle high |
| dbl_speed | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| cfg_bits | input | 4 | Data bit count (5 to 9, clamped) |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe when a word is ready |
| frame_err | output | 1 | Stop bit voted low |
| parity_err | output | 1 | Parity mismatch |

## Verification
Characters are sent at the nominal bit length and at bit lengths about 2.5 % shorter and longer, in both speed modes. This shows whether the sampling point drifts within the tolerated window and whether the voting indices are correct for each mode. Word lengths at and beyond both clamp limits, each parity setting, corrupted parity bits and low stop bits check the decoding and flag paths. A two-tick low spike tells glitch rejection apart from a real start. Characters whose stop bit is cut short just after the voting window, and configuration changes made during a character, show early re-arming and configuration capture. A behavioural model, run on every clock, pins the exact strobe cycle.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;

    localparam int DATA_W   = 9;
    localparam int NB_W     = 4;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_OFF     = 2'd0,
        PAR_EVEN    = 2'd1,
        PAR_ODD     = 2'd2,
        PAR_OFF_ALT = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic             dbl;
        logic [NB_W-1:0]  nbits;
        par_mode_e        par;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_result_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par_active(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic [NB_W-1:0] clamp_bits(input logic [NB_W-1:0] v);
        if (v < NB_W'(MIN_BITS))
            return NB_W'(MIN_BITS);
        else if (v > NB_W'(DATA_W))
            return NB_W'(DATA_W);
        else
            return v;
    endfunction

endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= RESET_VAL;
                else     stage_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= {STAGES{RESET_VAL}};
                else     stage_q <= {stage_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/uart_mv_sampler.sv
module uart_mv_sampler
    import uart_mv_pkg::*;
#(
    parameter int OSR_NORM  = 16,
    parameter int OSR_FAST  = 8,
    parameter int VOTE_NORM = 8,
    parameter int VOTE_FAST = 4,
    localparam int CNT_W    = $clog2(OSR_NORM + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    input  logic load,
    input  logic run,
    input  logic dbl,
    output logic vote_stb,
    output logic vote_bit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt_idx;
    logic [CNT_W-1:0] osr_len;
    logic [CNT_W-1:0] first_idx;
    logic             smp_a_q;
    logic             smp_b_q;

    always_comb begin
        osr_len   = dbl ? CNT_W'(OSR_FAST)  : CNT_W'(OSR_NORM);
        first_idx = dbl ? CNT_W'(VOTE_FAST) : CNT_W'(VOTE_NORM);
        nxt_idx   = (cnt_q >= osr_len) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end

    assign vote_stb = tick && run && (nxt_idx == first_idx + CNT_W'(2));
    assign vote_bit = maj3(smp_a_q, smp_b_q, din);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            smp_a_q <= 1'b1;
            smp_b_q <= 1'b1;
        end else if (tick) begin
            if (load) begin
                cnt_q <= CNT_W'(1);
            end else if (run) begin
                cnt_q <= nxt_idx;
                if (nxt_idx == first_idx)
                    smp_a_q <= din;
                if (nxt_idx == first_idx + CNT_W'(1))
                    smp_b_q <= din;
            end
        end
    end

endmodule

// File: rtl/uart_mv_frame.sv
module uart_mv_frame
    import uart_mv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       din,
    input  frame_cfg_t cfg_in,
    input  logic       vote_stb,
    input  logic       vote_bit,
    output logic       load,
    output logic       run,
    output logic       dbl_q,
    output rx_state_e  state,
    output par_mode_e  par_q,
    output rx_result_t result,
    output logic       result_stb
);

    logic              prev_q;
    logic [NB_W-1:0]   nb_q;
    logic [NB_W-1:0]   bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              perr_q;
    logic              last_data;

    assign load      = tick && (state == ST_IDLE) && prev_q && !din;
    assign run       = (state != ST_IDLE);
    assign last_data = (bit_idx == nb_q - NB_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            prev_q     <= 1'b1;
            dbl_q      <= 1'b0;
            nb_q       <= NB_W'(MIN_BITS);
            par_q      <= PAR_OFF;
            bit_idx    <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            perr_q     <= 1'b0;
            result     <= '0;
            result_stb <= 1'b0;
        end else begin
            result_stb <= 1'b0;
            if (tick)
                prev_q <= din;
            if (load) begin
                state   <= ST_START;
                dbl_q   <= cfg_in.dbl;
                nb_q    <= clamp_bits(cfg_in.nbits);
                par_q   <= cfg_in.par;
                bit_idx <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                perr_q  <= 1'b0;
            end else if (vote_stb) begin
                unique case (state)
                    ST_START: begin
                        state <= vote_bit ? ST_IDLE : ST_DATA;
                    end
                    ST_DATA: begin
                        shreg[bit_idx] <= vote_bit;
                        par_acc        <= par_acc ^ vote_bit;
                        if (last_data)
                            state <= par_active(par_q) ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + NB_W'(1);
                    end
                    ST_PARITY: begin
                        if (par_q == PAR_EVEN)
                            perr_q <= par_acc ^ vote_bit;
                        else
                            perr_q <= ~(par_acc ^ vote_bit);
                        state <= ST_STOP;
                    end
                    ST_STOP: begin
                        result.data <= shreg;
                        result.ferr <= ~vote_bit;
                        result.perr <= par_active(par_q) ? perr_q : 1'b0;
                        result_stb  <= 1'b1;
                        state       <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
    import uart_mv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OSR_NORM    = 16,
    parameter int OSR_FAST    = 8,
    parameter int VOTE_NORM   = 8,
    parameter int VOTE_FAST   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              dbl_speed,
    input  logic [NB_W-1:0]   cfg_bits,
    input  logic [1:0]        cfg_parity,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err
);

    logic       rxd_s;
    logic       smp_load;
    logic       smp_run;
    logic       smp_dbl;
    logic       smp_stb;
    logic       smp_bit;
    rx_state_e  fsm_state;
    par_mode_e  fsm_par;
    frame_cfg_t cfg_in;
    rx_result_t res;
    logic       res_stb;

    assign cfg_in = '{dbl: dbl_speed, nbits: cfg_bits, par: par_mode_e'(cfg_parity)};

    uart_mv_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_mv_sampler #(
        .OSR_NORM  (OSR_NORM),
        .OSR_FAST  (OSR_FAST),
        .VOTE_NORM (VOTE_NORM),
        .VOTE_FAST (VOTE_FAST)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .din      (rxd_s),
        .load     (smp_load),
        .run      (smp_run),
        .dbl      (smp_dbl),
        .vote_stb (smp_stb),
        .vote_bit (smp_bit)
    );

    uart_mv_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .din        (rxd_s),
        .cfg_in     (cfg_in),
        .vote_stb   (smp_stb),
        .vote_bit   (smp_bit),
        .load       (smp_load),
        .run        (smp_run),
        .dbl_q      (smp_dbl),
        .state      (fsm_state),
        .par_q      (fsm_par),
        .result     (res),
        .result_stb (res_stb)
    );

    assign rx_data    = res.data;
    assign frame_err  = res.ferr;
    assign parity_err = res.perr;
    assign rx_valid   = res_stb;

endmodule

// File: rtl/uart_mv_rx_chk.sv
module uart_mv_rx_chk
    import uart_mv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              frame_err,
    input logic              parity_err,
    input rx_state_e         fsm_state,
    input par_mode_e         fsm_par,
    input logic              smp_stb,
    input logic              smp_bit
);

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!rx_valid && rx_data == '0 && !frame_err && !parity_err));

    // R7
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));

    // R7
    p_valid_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(fsm_state) == ST_STOP && $past(tick)));

    // R5
    p_parity_off_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ($past(fsm_par) == PAR_OFF || $past(fsm_par) == PAR_OFF_ALT)) |-> !parity_err);

    // R6
    p_stop_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_STOP && smp_stb) |=> (rx_valid && frame_err == !$past(smp_bit)));

    // R8
    p_glitch_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_START && smp_stb && smp_bit) |=> (fsm_state == ST_IDLE));

    // R11
    p_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fsm_state));

endmodule

bind uart_mv_rx uart_mv_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .fsm_state  (fsm_state),
    .fsm_par    (fsm_par),
    .smp_stb    (smp_stb),
    .smp_bit    (smp_bit)
);

// File: tb/uart_mv_rx_bench.sv
module uart_mv_rx_bench;

    localparam int TICK_DIV = 5;
    localparam int BIT_N    = 80;
    localparam int BIT_D    = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       dbl_speed = 1'b0;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_parity = 2'd0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       frame_err;
    logic       parity_err;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    int exp_q[$];
    string req_q[$];

    always #4 clk = ~clk;

    uart_mv_rx u_uart_mv_rx (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .rxd        (rxd),
        .dbl_speed  (dbl_speed),
        .cfg_bits   (cfg_bits),
        .cfg_parity (cfg_parity),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // tick generator: one clock in TICK_DIV
    int tdiv = 0;
    always @(negedge clk) begin
        if (rst) begin
            tdiv = 0;
            tick = 1'b0;
        end else begin
            tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
            tick = (tdiv == 0);
        end
    end

    // behavioural reference, advanced on every rising edge
    int m_q1, m_q2, m_prev, m_st, m_idx, m_a, m_b, m_k, m_word, m_ones, m_perr;
    int m_nb, m_par, m_dbl;
    int e_valid, e_data, e_fe, e_pe;
    always @(posedge clk) begin
        int s, v, lim, first;
        if (rst) begin
            m_q1 = 1; m_q2 = 1; m_prev = 1; m_st = 0; m_idx = 0;
            e_valid = 0; e_data = 0; e_fe = 0; e_pe = 0;
        end else begin
            e_valid = 0;
            s = m_q2;
            m_q2 = m_q1;
            m_q1 = rxd;
            if (tick) begin
                if (m_st == 0) begin
                    if (m_prev == 1 && s == 0) begin
                        m_st = 1; m_idx = 1; m_k = 0; m_word = 0; m_ones = 0; m_perr = 0;
                        m_dbl = dbl_speed;
                        m_nb = (cfg_bits < 5) ? 5 : ((cfg_bits > 9) ? 9 : int'(cfg_bits));
                        m_par = cfg_parity;
                    end
                end else begin
                    lim = m_dbl ? 8 : 16;
                    first = m_dbl ? 4 : 8;
                    m_idx = (m_idx >= lim) ? 1 : m_idx + 1;
                    if (m_idx == first) m_a = s;
                    else if (m_idx == first + 1) m_b = s;
                    else if (m_idx == first + 2) begin
                        v = (m_a + m_b + s >= 2) ? 1 : 0;
                        case (m_st)
                            1: m_st = v ? 0 : 2;
                            2: begin
                                m_word = m_word | (v << m_k);
                                m_ones = m_ones + v;
                                if (m_k == m_nb - 1) m_st = (m_par == 1 || m_par == 2) ? 3 : 4;
                                else m_k++;
                            end
                            3: begin
                                m_perr = (m_par == 1) ? ((m_ones + v) % 2) : ((m_ones + v + 1) % 2);
                                m_st = 4;
                            end
                            default: begin
                                e_valid = 1; e_data = m_word; e_fe = 1 - v;
                                e_pe = (m_par == 1 || m_par == 2) ? m_perr : 0;
                                m_st = 0;
                            end
                        endcase
                    end
                end
                m_prev = s;
            end
        end
    end

    // per-clock comparison and scoreboard against sent characters
    always @(negedge clk) begin
        int e;
        string r;
        if (!rst) begin
            check(rx_valid == e_valid, "R7 R11 valid timing", rx_valid, e_valid);
            check(rx_data == e_data[8:0], "R4 data", rx_data, e_data);
            check(frame_err == e_fe[0], "R6 frame flag", frame_err, e_fe);
            check(parity_err == e_pe[0], "R5 parity flag", parity_err, e_pe);
            if (rx_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected word", rx_data, -1);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check({rx_data, frame_err, parity_err} == e[10:0], r,
                          {rx_data, frame_err, parity_err}, e);
                end
            end
        end
    end

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic d, input int nb, input int p);
        dbl_speed  = d;
        cfg_bits   = 4'(nb);
        cfg_parity = 2'(p);
    endtask

    task automatic send_frame(input int data, input int nb, input int par, input int bitclk,
                              input bit bad_par, input bit stop_val, input int stop_len,
                              input int gap, input bit scramble, input string req);
        int ones, mask, pb;
        ones = 0;
        mask = (1 << nb) - 1;
        for (int i = 0; i < nb; i++) ones += (data >> i) & 1;
        exp_q.push_back(((data & mask) << 2) | ((stop_val ? 0 : 1) << 1)
                        | ((par != 0 && bad_par) ? 1 : 0));
        req_q.push_back(req);
        hold(1'b0, bitclk);
        if (scramble) begin
            cfg_bits   = (cfg_bits == 4'd9) ? 4'd5 : 4'd9;
            cfg_parity = (cfg_parity == 2'd0) ? 2'd1 : 2'd0;
            dbl_speed  = ~dbl_speed;
        end
        for (int i = 0; i < nb; i++) hold(1'((data >> i) & 1), bitclk);
        if (par != 0) begin
            pb = (par == 1) ? (ones % 2) : (1 - ones % 2);
            if (bad_par) pb = 1 - pb;
            hold(1'(pb), bitclk);
        end
        hold(stop_val, stop_len);
        if (gap > 0) hold(1'b1, gap);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        // R1 during reset
        check(rx_valid == 0 && rx_data == 0 && !frame_err && !parity_err, "R1 reset state",
              {rx_data, rx_valid, frame_err, parity_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rx_valid == 0 && rx_data == 0, "R1 after reset", {rx_data, rx_valid}, 0);
        hold(1'b1, 50);

        // R2 normal speed, nominal and drifted rates
        set_cfg(0, 8, 0);
        send_frame('hA5, 8, 0, BIT_N,     0, 1, BIT_N, 40, 0, "R2 nominal");
        send_frame('h3C, 8, 0, BIT_N - 2, 0, 1, BIT_N, 40, 0, "R2 fast");
        send_frame('hC3, 8, 0, BIT_N + 2, 0, 1, BIT_N, 40, 0, "R2 slow");
        set_cfg(0, 9, 1);
        send_frame('h1B5, 9, 1, BIT_N + 2, 0, 1, BIT_N, 40, 0, "R2 slow long");
        send_frame('h0F0, 9, 1, BIT_N - 2, 0, 1, BIT_N, 40, 0, "R2 fast long");

        // R3 double speed
        set_cfg(1, 8, 0);
        send_frame('h5A, 8, 0, BIT_D,     0, 1, BIT_D, 30, 0, "R3 nominal");
        send_frame('h81, 8, 0, BIT_D - 1, 0, 1, BIT_D, 30, 0, "R3 fast");
        send_frame('h7E, 8, 0, BIT_D + 1, 0, 1, BIT_D, 30, 0, "R3 slow");
        set_cfg(1, 9, 2);
        send_frame('h155, 9, 2, BIT_D + 1, 0, 1, BIT_D, 30, 0, "R3 slow long");

        // R4 bit counts and clamping
        set_cfg(0, 5, 0);
        send_frame('h15, 5, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R4 five bits");
        set_cfg(0, 2, 0);
        send_frame('h0B, 5, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R4 clamp low");
        set_cfg(1, 12, 0);
        send_frame('h1C7, 9, 0, BIT_D, 0, 1, BIT_D, 30, 0, "R4 clamp high");
        set_cfg(0, 7, 0);
        send_frame('h41, 7, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R4 seven bits");

        // R5 parity modes and errors
        set_cfg(0, 8, 1);
        send_frame('h37, 8, 1, BIT_N, 0, 1, BIT_N, 40, 0, "R5 even ok");
        send_frame('h37, 8, 1, BIT_N, 1, 1, BIT_N, 40, 0, "R5 even bad");
        set_cfg(1, 6, 2);
        send_frame('h2D, 6, 2, BIT_D, 0, 1, BIT_D, 30, 0, "R5 odd ok");
        send_frame('h2D, 6, 2, BIT_D, 1, 1, BIT_D, 30, 0, "R5 odd bad");
        set_cfg(0, 8, 3);
        send_frame('h99, 8, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R5 mode three none");

        // R6 framing error, both modes
        set_cfg(0, 8, 0);
        send_frame('h66, 8, 0, BIT_N, 0, 0, BIT_N, 80, 0, "R6 stop low normal");
        set_cfg(1, 8, 1);
        send_frame('h13, 8, 1, BIT_D, 1, 0, BIT_D, 60, 0, "R6 stop low double");

        // R8 short spike is not a start
        set_cfg(0, 8, 0);
        v0 = n_valid;
        hold(1'b0, 2 * TICK_DIV);
        hold(1'b1, 3 * BIT_N);
        check(n_valid == v0, "R8 glitch produced word", n_valid - v0, 0);
        send_frame('hE7, 8, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R8 frame after glitch");
        set_cfg(1, 8, 0);
        v0 = n_valid;
        hold(1'b0, TICK_DIV);
        hold(1'b1, 3 * BIT_D);
        check(n_valid == v0, "R8 glitch double", n_valid - v0, 0);

        // R9 back-to-back with stop cut just after the voting window
        set_cfg(0, 8, 0);
        send_frame('h11, 8, 0, BIT_N, 0, 1, 11 * TICK_DIV, 0, 0, "R9 early normal a");
        send_frame('hEE, 8, 0, BIT_N, 0, 1, 11 * TICK_DIV, 0, 0, "R9 early normal b");
        send_frame('h42, 8, 0, BIT_N, 0, 1, BIT_N, 40, 0, "R9 early normal c");
        set_cfg(1, 9, 1);
        send_frame('h101, 9, 1, BIT_D, 0, 1, 7 * TICK_DIV, 0, 0, "R9 early double a");
        send_frame('h0FE, 9, 1, BIT_D, 0, 1, BIT_D, 40, 0, "R9 early double b");

        // R10 configuration changed mid-character
        set_cfg(0, 8, 0);
        send_frame('hB4, 8, 0, BIT_N, 0, 1, BIT_N, 0, 1, "R10 normal captured");
        set_cfg(0, 8, 0);
        hold(1'b1, 40);
        set_cfg(1, 6, 2);
        send_frame('h29, 6, 2, BIT_D, 0, 1, BIT_D, 0, 1, "R10 double captured");
        set_cfg(1, 6, 2);
        hold(1'b1, 40);

        hold(1'b1, 300);
        check(exp_q.size() == 0, "R7 words missing", exp_q.size(), 0);
        finish_run();
    end

endmodule